// File: doc/BRIEF.md
# Page Access Permission Evaluator

This block judges one memory access against the rights held in a two-level, 32-bit page mapping. A table walker hands it the directory entry and the table entry it fetched, says whether the directory entry maps a large page, and gives the access context: the privilege mode, whether the access is a write, and the state of the supervisor write-protect control. The block is purely combinational. In the same evaluation it returns three results: whether the access breaks protection, the error code to report if it does, and whether the translation that gets installed may allow writes.

For a small page, the user and read/write rights come from both levels combined by a bitwise AND. For a large page, the directory entry alone supplies them and the table entry is ignored. The walker checks the present bits, walks the tables and touches memory. This block does none of that. Its inputs and outputs are plain control pins with no handshake, because it holds no state and answers in the same cycle.

Top module: `page_perm_eval`

## Requirements
- R1: With `large_pg`=0, the effective user right is dir[2] AND tbl[2], and the effective write right is dir[1] AND tbl[1]. Either level can remove a right.
- R2: With `large_pg`=1, the effective rights are dir[2] and dir[1] alone, and no value of `tbl_entry` changes any output.
- R3: With `user_mode`=1, the access faults when the effective user right is 0, for reads and for writes.
- R4: With `user_mode`=1 and `wr_req`=1, the access faults when the effective write right is 0.
- R5: With `user_mode`=0, the access faults only when `wr_req`=1, `wp_en`=1, the effective user right is 1 and the effective write right is 0. A supervisor read never faults.
- R6: With `user_mode`=1 and no fault, `map_wr_ok` equals the effective write right.
- R7: With `user_mode`=0 and no fault, `map_wr_ok` is 1 when `wp_en`=0, or the effective user right is 0, or the effective write right is 1. Otherwise it is 0.
- R8: On a fault, `fault_code` bit 0 is 1 (protection violation), bit 1 equals `wr_req` and bit 2 equals `user_mode`. Without a fault, `fault_code` is 0 and `map_wr_ok` is the only result that matters.
- R9: Entry bits other than bit 1 (write right) and bit 2 (user right) have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dir_entry | input | 32 | Directory-level entry fetched by the walker |
| tbl_entry | input | 32 | Table-level entry; don't-care for large pages |
| large_pg | input | 1 | Directory entry maps a large page directly |
| user_mode | input | 1 | Access is made at user privilege |
| wr_req | input | 1 | Access is a write |
| wp_en | input | 1 | Supervisor write-protect control |
| prot_fault | output | 1 | Access violates the combined rights |
| fault_code | output | 3 | Error code: bit0 protection, bit1 write, bit2 user; zero without fault |
| map_wr_ok | output | 1 | Installed mapping may be written; 0 on fault |

## Verification
The fault decision and the write-grant decision are made from the same merged rights in the same evaluation, so a single input pattern shows both. A supervisor write with write-protect set to a user page that one level marks read-only has to raise the fault and drop the grant at once. A supervisor read of the same page must not fault, yet the grant must still stay low. The bench drives every combination of both entries' rights, mode, write and write-protect for small and for large pages. It checks the fault flag, the code and the grant of each combination together against a model built from the requirements.

// File: rtl/ppe_pkg.sv
package ppe_pkg;
  typedef struct packed {
    logic usr;
    logic wr;
  } rights_t;

  typedef struct packed {
    logic usr_mode;
    logic is_wr;
    logic wp;
  } ctx_t;
endpackage

// File: rtl/ppe_rights_merge.sv
module ppe_rights_merge #(
  parameter int ENTRY_W = 32,
  parameter int USR_POS = 2,
  parameter int WR_POS  = 1
) (
  input  logic [ENTRY_W-1:0] dir_e,
  input  logic [ENTRY_W-1:0] tbl_e,
  input  logic               big,
  output ppe_pkg::rights_t   eff
);
  localparam int NFIELD = 2;
  localparam int POS [NFIELD] = '{USR_POS, WR_POS};

  logic [NFIELD-1:0] merged;

  for (genvar i = 0; i < NFIELD; i++) begin : g_field
    assign merged[i] = big ? dir_e[POS[i]] : (dir_e[POS[i]] & tbl_e[POS[i]]);
  end

  assign eff.usr = merged[0];
  assign eff.wr  = merged[1];

  always_comb begin
    // R1
    small_narrow_chk: assert (big || !eff.usr || (dir_e[USR_POS] && tbl_e[USR_POS]));
    // R2
    large_dir_only_chk: assert (!big || (eff.wr == dir_e[WR_POS]));
  end
endmodule

// File: rtl/ppe_fault_judge.sv
module ppe_fault_judge (
  input  ppe_pkg::rights_t eff,
  input  ppe_pkg::ctx_t    ctx,
  output logic             fault,
  output logic [2:0]       code
);
  logic usr_viol, sup_viol;

  always_comb begin
    usr_viol = ctx.usr_mode && (!eff.usr || (ctx.is_wr && !eff.wr));
    sup_viol = !ctx.usr_mode && ctx.is_wr && ctx.wp && eff.usr && !eff.wr;
    fault    = usr_viol || sup_viol;
    code     = fault ? {ctx.usr_mode, ctx.is_wr, 1'b1} : 3'b000;
  end

  always_comb begin
    // R5
    sup_read_safe_chk: assert (ctx.usr_mode || ctx.is_wr || !fault);
    // R8
    code_zero_chk: assert (fault || code == 3'b000);
  end
endmodule

// File: rtl/ppe_write_grant.sv
module ppe_write_grant (
  input  ppe_pkg::rights_t eff,
  input  ppe_pkg::ctx_t    ctx,
  input  logic             fault,
  output logic             wr_ok
);
  logic raw;

  always_comb begin
    if (ctx.usr_mode) raw = eff.wr;
    else              raw = !ctx.wp || !eff.usr || eff.wr;
    wr_ok = raw && !fault;
  end

  always_comb begin
    // R6
    user_grant_chk: assert (!(ctx.usr_mode && wr_ok) || eff.wr);
  end
endmodule

// File: rtl/page_perm_eval.sv
module page_perm_eval #(
  parameter int ENTRY_W = 32,
  parameter int USR_POS = 2,
  parameter int WR_POS  = 1
) (
  input  logic [ENTRY_W-1:0] dir_entry,
  input  logic [ENTRY_W-1:0] tbl_entry,
  input  logic               large_pg,
  input  logic               user_mode,
  input  logic               wr_req,
  input  logic               wp_en,
  output logic               prot_fault,
  output logic [2:0]         fault_code,
  output logic               map_wr_ok
);
  ppe_pkg::rights_t eff;
  ppe_pkg::ctx_t    ctx;

  assign ctx = '{usr_mode: user_mode, is_wr: wr_req, wp: wp_en};

  ppe_rights_merge #(.ENTRY_W(ENTRY_W), .USR_POS(USR_POS), .WR_POS(WR_POS)) u_merge (
    .dir_e (dir_entry),
    .tbl_e (tbl_entry),
    .big   (large_pg),
    .eff   (eff)
  );

  ppe_fault_judge u_judge (
    .eff   (eff),
    .ctx   (ctx),
    .fault (prot_fault),
    .code  (fault_code)
  );

  ppe_write_grant u_grant (
    .eff   (eff),
    .ctx   (ctx),
    .fault (prot_fault),
    .wr_ok (map_wr_ok)
  );

  always_comb begin
    // R3
    user_no_usr_chk: assert (!(user_mode && !eff.usr) || prot_fault);
    // R4
    user_ro_write_chk: assert (!(user_mode && wr_req && !eff.wr) || prot_fault);
    // R8
    code_ctx_chk: assert (!prot_fault || (fault_code == {user_mode, wr_req, 1'b1}));
    // R7
    sup_grant_chk: assert (user_mode || prot_fault || (map_wr_ok == (!wp_en || !eff.usr || eff.wr)));
  end
endmodule

// File: tb/page_perm_eval_test.sv
module page_perm_eval_test;
  logic        clk = 1'b0;
  logic [31:0] dir_entry, tbl_entry;
  logic        large_pg, user_mode, wr_req, wp_en;
  logic        prot_fault, map_wr_ok;
  logic [2:0]  fault_code;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  page_perm_eval uut (
    .dir_entry(dir_entry), .tbl_entry(tbl_entry), .large_pg(large_pg),
    .user_mode(user_mode), .wr_req(wr_req), .wp_en(wp_en),
    .prot_fault(prot_fault), .fault_code(fault_code), .map_wr_ok(map_wr_ok)
  );

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [31:0] d, input logic [31:0] t, input logic lg,
                       input logic um, input logic w, input logic wp);
    @(negedge clk);
    dir_entry = d; tbl_entry = t; large_pg = lg;
    user_mode = um; wr_req = w; wp_en = wp;
    #1;
  endtask

  task automatic model(input logic [31:0] d, input logic [31:0] t, input logic lg,
                       input logic um, input logic w, input logic wp,
                       output logic f, output logic [2:0] c, output logic g);
    logic u, r;
    u = lg ? d[2] : (d[2] & t[2]);
    r = lg ? d[1] : (d[1] & t[1]);
    if (um) f = !u || (w && !r);
    else    f = w && wp && u && !r;
    c = f ? {um, w, 1'b1} : 3'b000;
    if (f)       g = 1'b0;
    else if (um) g = r;
    else         g = !wp || !u || r;
  endtask

  task automatic t_reset;
    apply(32'h0, 32'h0, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R5 idle fault", {3'b0, prot_fault}, 4'h0);
    chk("R8 idle code", {1'b0, fault_code}, 4'h0);
    chk("R7 idle grant", {3'b0, map_wr_ok}, 4'h1);
  endtask

  task automatic t_sweep(input logic lg);
    for (int i = 0; i < 128; i++) begin
      logic [31:0] d, t;
      logic f, g; logic [2:0] c;
      d = {29'h0, i[1:0], 1'b1};
      t = {29'h0, i[3:2], 1'b1};
      model(d, t, lg, i[4], i[5], i[6], f, c, g);
      apply(d, t, lg, i[4], i[5], i[6]);
      chk(i[4] ? "R3/R4 user fault" : "R5 sup fault", {3'b0, prot_fault}, {3'b0, f});
      chk("R8 code", {1'b0, fault_code}, {1'b0, c});
      chk(i[4] ? "R6 user grant" : "R7 sup grant", {3'b0, map_wr_ok}, {3'b0, g});
    end
  endtask

  task automatic t_narrow;
    // R1: table level drops user right
    apply(32'h6, 32'h2, 1'b0, 1'b1, 1'b0, 1'b0);
    chk("R1 tbl removes user", {prot_fault, fault_code}, 4'hD);
    // R1: directory drops write right
    apply(32'h4, 32'h6, 1'b0, 1'b1, 1'b1, 1'b0);
    chk("R1 dir removes write", {prot_fault, fault_code}, 4'hF);
    // R5: supervisor write, wp, user read-only page
    apply(32'h6, 32'h4, 1'b0, 1'b0, 1'b1, 1'b1);
    chk("R5 sup wp fault", {prot_fault, fault_code}, 4'hB);
    chk("R7 grant dropped", {3'b0, map_wr_ok}, 4'h0);
    apply(32'h6, 32'h4, 1'b0, 1'b0, 1'b0, 1'b1);
    chk("R5 sup read ok", {3'b0, prot_fault}, 4'h0);
    chk("R7 sup read grant", {3'b0, map_wr_ok}, 4'h0);
  endtask

  task automatic t_large_ignore;
    apply(32'h6, 32'h0, 1'b1, 1'b1, 1'b1, 1'b1);
    chk("R2 large tbl zero", {prot_fault, map_wr_ok, fault_code[1:0]}, 4'h4);
    apply(32'h6, 32'hFFFF_FFFF, 1'b1, 1'b1, 1'b1, 1'b1);
    chk("R2 large tbl ones", {prot_fault, map_wr_ok, fault_code[1:0]}, 4'h4);
    apply(32'h4, 32'hFFFF_FFFF, 1'b1, 1'b1, 1'b1, 1'b0);
    chk("R2 large dir ro", {prot_fault, fault_code}, 4'hF);
  endtask

  task automatic t_other_bits;
    apply(32'hFFFF_FFF9, 32'hFFFF_FFFF, 1'b0, 1'b1, 1'b0, 1'b0);
    chk("R9 dir noise user", {prot_fault, fault_code}, 4'hD);
    apply(32'h0000_0006, 32'hFFFF_FFF9 | 32'h6, 1'b0, 1'b1, 1'b1, 1'b1);
    chk("R9 noise allowed", {prot_fault, map_wr_ok, 2'b0}, 4'h4);
  endtask

  initial begin
    t_reset();
    t_narrow();
    t_large_ignore();
    t_other_bits();
    t_sweep(1'b0);
    t_sweep(1'b1);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule